// File: doc/BRIEF.md
# Mixed-Radix Depth Iteration Generator

This block is the loop controller for a fully pipelined probability datapath. A nested loop over up to three interaction depths, each running from 0 to 19 in 1 mm steps, is flattened into one binary counter. Each flat index is then split back into base-20 digits by a short chain of divide-by-20 stages, each one register deep. One iteration issues per clock, so the datapath behind it never waits on a bit-serial divider.

Software or a sequencer pulses `start_i` with the interaction count on `sel_i`. The block looks up the trip count (20, 400 or 8,000), streams the digit tuples out with a valid/ready handshake, flags the final tuple and pulses `done_o` once that tuple has been taken. A count of zero or above three is rejected with a one-cycle error pulse and produces nothing. When `ready_i` is low, the counter and every divider stage freeze together.

Top module: `depth_iter_gen`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `busy_o`, `valid_o`, `last_o`, `done_o` and `err_o` are all 0.
- R2: A start accepted with `sel_i` = 1, 2 or 3 yields exactly 20, 400 or 8,000 transfers (cycles with `valid_o` and `ready_i` both high). The flat indices behind them run from 0 upward in steps of one.
- R3: For flat index k, `depth_o[4:0]` = k mod 20, `depth_o[9:5]` = (k / 20) mod 20 and `depth_o[14:10]` = k / 400. Every digit lies in 0..19.
- R4: Digit fields beyond the selected interaction count read 0: bits [14:10] when `sel_i` was 1 or 2, and bits [9:5] when it was 1.
- R5: `last_o` is 1 on the transfer of the final index (count − 1) and on no other transfer. `last_o` is never high without `valid_o`.
- R6: `done_o` is a one-cycle pulse in the cycle after the final transfer. In that cycle `busy_o` is already 0.
- R7: A start with `sel_i` equal to 0 or to 4..7 while idle raises `err_o` for exactly one cycle, in the cycle after the start edge. No transfer follows and `busy_o` stays 0.
- R8: While `valid_o` is high and `ready_i` is low, the next cycle still shows `valid_o` high with the same `depth_o` and `last_o`. No index is dropped or repeated.
- R9: `start_i` is ignored while `busy_o` is high. The run in progress keeps its count and digit masking.
- R10: With `ready_i` held high, `valid_o` rises on the third clock edge after the edge that accepts the start. The transfers then follow on consecutive cycles, one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled only while idle |
| sel_i | input | 3 | Interaction count; valid values are 1..3 |
| ready_i | input | 1 | Downstream ready; low freezes the whole unit |
| busy_o | output | 1 | Run in progress (counter or divider stages occupied) |
| done_o | output | 1 | One-cycle pulse after the final transfer |
| err_o | output | 1 | One-cycle pulse for a rejected interaction count |
| valid_o | output | 1 | Digit tuple on `depth_o` is valid |
| last_o | output | 1 | Current tuple carries the final index |
| depth_o | output | 15 | Three 5-bit depth digits; depth 1 in bits [4:0] |

## Verification
The bench runs each interaction count and compares every tuple against an independent model of the index, which catches a wrong divisor, a swapped digit slot, or a counter that stops at the wrong trip count or skips an index. Random ready stalls check that a frozen output really holds; a stage that advanced on its own would duplicate or lose a tuple. A restart request during a two-interaction run checks that the run keeps its length and that its top digit stays masked. Invalid counts of 0 and 5 check that the error pulse is not treated as a run of zero or of several thousand iterations. The bench also measures the start-to-first-output latency and the spacing of the done pulse, which would expose a missing or extra pipeline register.

// File: rtl/dig_pkg.sv
// Package: shared defaults and helpers for the depth iteration generator.
// Assumes RADIX >= 2 and a level count of at most 7 (pow_of loop bound).
package dig_pkg;
    localparam int RADIX  = 20;
    localparam int LEVELS = 3;
    localparam int SEL_W  = 3;
    localparam int DIG_W  = $clog2(RADIX);
    localparam int IDX_W  = $clog2(RADIX ** LEVELS);

    // Integer power radix**n for small n; used for the trip-count table.
    function automatic int unsigned pow_of(input int unsigned radix, input int unsigned n);
        int unsigned r;
        r = 1;
        for (int i = 0; i < 8; i++) begin
            if (i < n) r = r * radix;
        end
        return r;
    endfunction
endpackage

// File: rtl/dig_counter.sv
// Flat index generator. Accepts a start while the whole unit is idle,
// looks up the trip count radix**sel, and issues one index per cycle in
// which adv_i is high. Assumes idle_i already covers the downstream stages.
module dig_counter #(
    parameter int RADIX  = dig_pkg::RADIX,
    parameter int LEVELS = dig_pkg::LEVELS,
    parameter int SEL_W  = dig_pkg::SEL_W,
    parameter int IDX_W  = dig_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             idle_i,
    input  logic             adv_i,
    output logic             active_o,
    output logic             err_o,
    output logic [SEL_W-1:0] mode_o,
    output logic             v_o,
    output logic             last_o,
    output logic [IDX_W-1:0] idx_o
);
    logic             sel_ok;
    logic             take;
    logic [IDX_W-1:0] nxt_q;
    logic [IDX_W-1:0] end_q;

    // Decide whether a start request is legal and accepted this cycle.
    always_comb begin
        sel_ok = (sel_i >= SEL_W'(1)) && (sel_i <= SEL_W'(LEVELS));
        take   = start_i && idle_i && sel_ok;
    end

    // Run control: load the trip count, step the index, flag rejects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            err_o    <= 1'b0;
            mode_o   <= '0;
            nxt_q    <= '0;
            end_q    <= '0;
        end else begin
            err_o <= start_i && idle_i && !sel_ok;
            if (take) begin
                active_o <= 1'b1;
                mode_o   <= sel_i;
                nxt_q    <= '0;
                end_q    <= IDX_W'(dig_pkg::pow_of(RADIX, 32'(sel_i)) - 1);
            end else if (adv_i && active_o) begin
                nxt_q <= nxt_q + IDX_W'(1);
                if (nxt_q == end_q) active_o <= 1'b0;
            end
        end
    end

    // Issue register: stage 0 of the pipeline, frozen when adv_i is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            last_o <= 1'b0;
            idx_o  <= '0;
        end else if (adv_i) begin
            v_o    <= active_o;
            last_o <= active_o && (nxt_q == end_q);
            idx_o  <= nxt_q;
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> (idx_o <= end_q)); // R2
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |=> $stable(mode_o)); // R9
endmodule

// File: rtl/dig_divstage.sv
// One divide-by-radix stage. Registers quotient and remainder of its input
// in a single cycle and drops the remainder into digit slot SLOT. The stage
// holds its contents while adv_i is low. Assumes the input is below radix**LEVELS.
module dig_divstage #(
    parameter int RADIX  = dig_pkg::RADIX,
    parameter int LEVELS = dig_pkg::LEVELS,
    parameter int DIG_W  = dig_pkg::DIG_W,
    parameter int IDX_W  = dig_pkg::IDX_W,
    parameter int SLOT   = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv_i,
    input  logic                    v_i,
    input  logic                    last_i,
    input  logic [IDX_W-1:0]        quo_i,
    input  logic [LEVELS*DIG_W-1:0] dig_i,
    output logic                    v_o,
    output logic                    last_o,
    output logic [IDX_W-1:0]        quo_o,
    output logic [LEVELS*DIG_W-1:0] dig_o
);
    // Pipeline register: split the quotient and pass earlier digits along.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            last_o <= 1'b0;
            quo_o  <= '0;
            dig_o  <= '0;
        end else if (adv_i) begin
            v_o    <= v_i;
            last_o <= last_i;
            quo_o  <= quo_i / IDX_W'(RADIX);
            dig_o  <= dig_i;
            dig_o[SLOT*DIG_W +: DIG_W] <= DIG_W'(quo_i % IDX_W'(RADIX));
        end
    end
endmodule

// File: rtl/depth_iter_gen.sv
// Depth iteration generator top. A flat counter feeds LEVELS-1 divide
// stages; the last quotient becomes the top digit. One global advance
// (ready_i) moves every register, so the pipeline never drops a tuple.
// Assumes the consumer takes a tuple in any cycle with valid_o and ready_i high.
module depth_iter_gen #(
    parameter int RADIX  = dig_pkg::RADIX,
    parameter int LEVELS = dig_pkg::LEVELS,
    parameter int SEL_W  = dig_pkg::SEL_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic [SEL_W-1:0]                     sel_i,
    input  logic                                 ready_i,
    output logic                                 busy_o,
    output logic                                 done_o,
    output logic                                 err_o,
    output logic                                 valid_o,
    output logic                                 last_o,
    output logic [LEVELS*$clog2(RADIX)-1:0]      depth_o
);
    localparam int DIG_W = $clog2(RADIX);
    localparam int IDX_W = $clog2(RADIX ** LEVELS);
    localparam int LAST  = LEVELS - 1;

    logic                    st_v    [0:LEVELS-1];
    logic                    st_last [0:LEVELS-1];
    logic [IDX_W-1:0]        st_quo  [0:LEVELS-1];
    logic [LEVELS*DIG_W-1:0] st_dig  [0:LEVELS-1];
    logic                    active;
    logic                    idle;
    logic [SEL_W-1:0]        mode;
    logic [LEVELS*DIG_W-1:0] raw;

    // Occupancy: busy while the counter or any stage holds work.
    always_comb begin
        busy_o = active;
        for (int i = 0; i < LEVELS; i++) busy_o = busy_o | st_v[i];
        idle = !busy_o;
    end

    dig_counter #(
        .RADIX (RADIX),
        .LEVELS(LEVELS),
        .SEL_W (SEL_W),
        .IDX_W (IDX_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .sel_i   (sel_i),
        .idle_i  (idle),
        .adv_i   (ready_i),
        .active_o(active),
        .err_o   (err_o),
        .mode_o  (mode),
        .v_o     (st_v[0]),
        .last_o  (st_last[0]),
        .idx_o   (st_quo[0])
    );
    assign st_dig[0] = '0;

    generate
        for (genvar k = 1; k < LEVELS; k++) begin : g_div
            dig_divstage #(
                .RADIX (RADIX),
                .LEVELS(LEVELS),
                .DIG_W (DIG_W),
                .IDX_W (IDX_W),
                .SLOT  (k - 1)
            ) u_div (
                .clk   (clk),
                .rst_n (rst_n),
                .adv_i (ready_i),
                .v_i   (st_v[k-1]),
                .last_i(st_last[k-1]),
                .quo_i (st_quo[k-1]),
                .dig_i (st_dig[k-1]),
                .v_o   (st_v[k]),
                .last_o(st_last[k]),
                .quo_o (st_quo[k]),
                .dig_o (st_dig[k])
            );
        end
    endgenerate

    // Final digit tuple: the last quotient fills the top slot.
    always_comb begin
        raw = st_dig[LAST];
        raw[LAST*DIG_W +: DIG_W] = DIG_W'(st_quo[LAST]);
    end

    generate
        for (genvar j = 0; j < LEVELS; j++) begin : g_mask
            assign depth_o[j*DIG_W +: DIG_W] =
                (mode > SEL_W'(j)) ? raw[j*DIG_W +: DIG_W] : '0;
            AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                valid_o |-> (depth_o[j*DIG_W +: DIG_W] < DIG_W'(RADIX))); // R3
        end
    endgenerate

    assign valid_o = st_v[LAST];
    assign last_o  = st_last[LAST];

    // Completion pulse once the final tuple has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= ready_i && st_v[LAST] && st_last[LAST];
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(depth_o) && $stable(last_o)); // R8
    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_o && last_o && ready_i)); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6
    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o && !valid_o); // R7
endmodule

// File: tb/depth_iter_gen_tb.sv
// Directed bench for depth_iter_gen: one task per scenario, each task
// checking its own results; a negedge monitor checks every transfer.
module depth_iter_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  sel_i = 3'd0;
    logic        ready_i = 1'b1;
    logic        busy_o, done_o, err_o, valid_o, last_o;
    logic [14:0] depth_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_idx = 0;
    int total = 0;
    int cur_mode = 0;
    bit stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int wd = 0;

    bit          fire_prev = 1'b0;
    bit          stall_prev = 1'b0;
    logic [14:0] hold_dep;
    logic        hold_last;

    always #2 clk = ~clk;

    depth_iter_gen u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .sel_i  (sel_i),
        .ready_i(ready_i),
        .busy_o (busy_o),
        .done_o (done_o),
        .err_o  (err_o),
        .valid_o(valid_o),
        .last_o (last_o),
        .depth_o(depth_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Ready pattern: always high unless the stall scenario is running.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ready_i = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    // Transfer monitor: digits, last flag, done timing and stall hold.
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev) begin
                chk(valid_o == 1'b1, "R8", "valid held", int'(valid_o), 1);
                chk(depth_o == hold_dep && last_o == hold_last, "R8", "tuple held",
                    int'(depth_o), int'(hold_dep));
            end
            if (done_o || fire_prev)
                chk(done_o == fire_prev, "R6", "done after final transfer",
                    int'(done_o), int'(fire_prev));
            if (valid_o && ready_i) begin
                chk(int'(depth_o[4:0]) == exp_idx % 20, "R3", "depth1",
                    int'(depth_o[4:0]), exp_idx % 20);
                chk(int'(depth_o[9:5]) == (cur_mode >= 2 ? (exp_idx / 20) % 20 : 0),
                    "R4", "depth2", int'(depth_o[9:5]),
                    cur_mode >= 2 ? (exp_idx / 20) % 20 : 0);
                chk(int'(depth_o[14:10]) == (cur_mode == 3 ? exp_idx / 400 : 0),
                    "R4", "depth3", int'(depth_o[14:10]),
                    cur_mode == 3 ? exp_idx / 400 : 0);
                chk(last_o == (exp_idx == total - 1), "R5", "last flag",
                    int'(last_o), int'(exp_idx == total - 1));
                exp_idx++;
            end
            fire_prev  = valid_o && ready_i && last_o;
            stall_prev = valid_o && !ready_i;
            hold_dep   = depth_o;
            hold_last  = last_o;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", wd);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic t_reset();
        @(negedge clk);
        chk(!busy_o && !valid_o && !last_o && !done_o && !err_o, "R1",
            "outputs after reset",
            int'({busy_o, valid_o, last_o, done_o, err_o}), 0);
    endtask

    // One run with the given interaction count; optional stalls and restart poke.
    task automatic t_run(input int n, input bit stall, input bit poke);
        int cyc;
        cur_mode = n;
        total    = (n == 1) ? 20 : (n == 2) ? 400 : 8000;
        exp_idx  = 0;
        stall_en = stall;
        @(posedge clk); #1;
        start_i = 1'b1;
        sel_i   = 3'(n);
        @(posedge clk); #1;
        start_i = 1'b0;
        if (!stall) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(valid_o == 1'b0, "R10", "no output before latency", int'(valid_o), 0);
            end
            @(negedge clk);
            chk(valid_o == 1'b1, "R10", "first output latency", int'(valid_o), 1);
        end
        if (poke) begin
            @(posedge clk); #1;
            start_i = 1'b1;
            sel_i   = 3'd3;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        cyc = 0;
        while (!done_o && cyc < 40000) begin
            @(negedge clk);
            cyc++;
        end
        if (!stall && !poke)
            chk(cyc == total, "R10", "cycles first output to done", cyc, total);
        chk(exp_idx == total, poke ? "R9" : "R2", "transfer count", exp_idx, total);
        chk(busy_o == 1'b0, "R6", "busy low at done", int'(busy_o), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R6", "done single pulse", int'(done_o), 0);
        stall_en = 1'b0;
    endtask

    // Rejected interaction count: error pulse and no iterations.
    task automatic t_bad(input int s);
        bit quiet;
        @(posedge clk); #1;
        start_i = 1'b1;
        sel_i   = 3'(s);
        @(posedge clk); #1;
        start_i = 1'b0;
        @(negedge clk);
        chk(err_o == 1'b1 && busy_o == 1'b0, "R7", "error pulse", int'({err_o, busy_o}), 2);
        @(negedge clk);
        chk(err_o == 1'b0, "R7", "error lasts one cycle", int'(err_o), 0);
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (valid_o || busy_o) quiet = 1'b0;
        end
        chk(quiet, "R7", "no iterations after reject", int'(quiet), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_run(1, 1'b0, 1'b0);
        t_run(2, 1'b0, 1'b1);
        t_run(3, 1'b0, 1'b0);
        t_run(2, 1'b1, 1'b0);
        t_bad(0);
        t_bad(5);
        t_run(1, 1'b1, 1'b0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule